// File: doc/BRIEF.md
# Two-Wide Issue Packet Checker

This block sits between an instruction queue and the reservation stations of an out-of-order core. Each cycle it looks at the two oldest queue entries, called slot 0 (older) and slot 1 (younger). From the free station count of each unit class and the number of free reorder-buffer (ROB) entries it decides whether zero, one or two of them issue. All checks are combinational and finish within the cycle. The second instruction's checks run in parallel with the first's, and they count what the first instruction claims, so program order holds inside the packet.

The block also keeps the register status table. For every architectural register the table records whether a result is pending, and if so the ROB tag of its producer. Every source of both slots is looked up in this table. A source of slot 1 that slot 0 writes takes slot 0's ROB tag directly. Issued instructions that write a register mark it pending under their own tag at the clock edge. A commit whose tag matches clears the mark. A flush suppresses issue and clears every pending mark.

Top module: `ipk_issue_checker`

## Requirements
- R1: Slot 0 issues (`issue0`=1) exactly when `q0_valid`=1, `flush`=0, `rob_free`>=1, and the free count of its class is non-zero. The free count of class c is `rs_free[c*CNT_W +: CNT_W]`. The class codes are 0 integer ALU, 1 memory, 2 floating point, 3 branch.
- R2: Slot 1 never issues when `rob_free` is below 2.
- R3: Slot 1 issues exactly when slot 0 issues, `q1_valid`=1, neither slot holds a branch, `rob_free`>=2, and its class has at least one free station. When both slots have the same class, that class needs at least two free stations.
- R4: If either slot holds a branch (class 3), at most slot 0 issues that cycle.
- R5: Slot 1 never issues in a cycle where slot 0 does not issue, whatever slot 1's own resources.
- R6: While `flush`=1 neither slot issues. At that clock edge every register in the table becomes not pending, and any commit in the same cycle is ignored.
- R7: `dst_tag0` equals `rob_tail`. `dst_tag1` equals `rob_tail`+1, wrapping from ROB_DEPTH-1 to 0.
- R8: If `q0_valid`=1, `q0_dst_we`=1 and a slot 1 source equals `q0_dst`, that source reports pending=1 with tag `dst_tag0`, whatever the table holds.
- R9: Every other source reports the table contents as they stood before the current edge: pending with its tag, or pending=0 with tag 0.
- R10: At the edge, each issued instruction with its destination-write flag set marks its destination pending under its own dest tag. When both write the same register, slot 1's tag is kept.
- R11: A commit (`commit_valid`=1) clears the pending mark of `commit_reg` only when the stored tag equals `commit_tag` and no issuing instruction writes that register at the same edge. A mismatched tag leaves the entry unchanged.
- R12: After reset every register reports pending=0 with tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Squash: no issue, clear pending marks |
| q0_valid | input | 1 | Slot 0 holds an instruction |
| q0_class | input | 2 | Slot 0 unit class |
| q0_src1 | input | REG_W | Slot 0 first source register |
| q0_src2 | input | REG_W | Slot 0 second source register |
| q0_dst | input | REG_W | Slot 0 destination register |
| q0_dst_we | input | 1 | Slot 0 writes a register |
| q1_valid | input | 1 | Slot 1 holds an instruction |
| q1_class | input | 2 | Slot 1 unit class |
| q1_src1 | input | REG_W | Slot 1 first source register |
| q1_src2 | input | REG_W | Slot 1 second source register |
| q1_dst | input | REG_W | Slot 1 destination register |
| q1_dst_we | input | 1 | Slot 1 writes a register |
| rs_free | input | 4*CNT_W | Free stations per class, class c at c*CNT_W |
| rob_free | input | ROBC_W | Free ROB entries |
| rob_tail | input | TAG_W | Next ROB tag to allocate |
| commit_valid | input | 1 | A result commits this cycle |
| commit_reg | input | REG_W | Register of the committing result |
| commit_tag | input | TAG_W | ROB tag of the committing result |
| issue0 | output | 1 | Slot 0 issues |
| issue1 | output | 1 | Slot 1 issues |
| dst_tag0 | output | TAG_W | ROB tag given to slot 0 |
| dst_tag1 | output | TAG_W | ROB tag given to slot 1 |
| s0a_pend | output | 1 | Slot 0 source 1 waits on a producer |
| s0a_tag | output | TAG_W | Slot 0 source 1 producer tag |
| s0b_pend | output | 1 | Slot 0 source 2 waits on a producer |
| s0b_tag | output | TAG_W | Slot 0 source 2 producer tag |
| s1a_pend | output | 1 | Slot 1 source 1 waits on a producer |
| s1a_tag | output | TAG_W | Slot 1 source 1 producer tag |
| s1b_pend | output | 1 | Slot 1 source 2 waits on a producer |
| s1b_tag | output | TAG_W | Slot 1 source 2 producer tag |

## Verification
The issue decisions depend only on the current inputs, so an error in them shows on `issue0` or `issue1` in the same cycle. The register status table is the only state. A wrong entry appears one edge after the write, commit or flush that caused it, as a wrong pending flag or tag on any source lookup of that register. The bench therefore compares every lookup every cycle against its own table model, and it probes specific registers after same-destination packets, commits with a mismatched tag, and flushes.

// File: rtl/ipk_pkg.sv
// Shared types of the issue packet checker.
// Assumes a two-bit unit class code; the branch class is code 3.
package ipk_pkg;
    localparam int NUM_CLASS = 4;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_MEM = 2'd1,
        CLS_FPU = 2'd2,
        CLS_BR  = 2'd3
    } unit_cls_e;
endpackage

// File: rtl/ipk_resource_check.sv
// Decides how many of the two oldest queue entries issue this cycle.
// Slot 1's station check counts the station that slot 0 claims. Branches issue alone.
// Assumes the free counts describe the state before this cycle's issue.
module ipk_resource_check
    import ipk_pkg::*;
#(
    parameter int CNT_W  = 3,
    parameter int ROBC_W = 5
) (
    input  logic                       flush,
    input  logic                       v0,
    input  logic                       v1,
    input  unit_cls_e                  cls0,
    input  unit_cls_e                  cls1,
    input  logic [NUM_CLASS*CNT_W-1:0] rs_free,
    input  logic [ROBC_W-1:0]          rob_free,
    output logic                       issue0,
    output logic                       issue1
);
    logic [NUM_CLASS-1:0] has_one;
    logic [NUM_CLASS-1:0] has_two;

    // Per class: at least one free station, and at least two free stations.
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        assign has_one[c] = rs_free[c*CNT_W +: CNT_W] != '0;
        assign has_two[c] = rs_free[c*CNT_W +: CNT_W] >= CNT_W'(2);
    end

    logic same_cls;
    logic st1_ok;
    logic any_br;

    // Slot 0 checks on their own; slot 1 checks include slot 0's claim.
    always_comb begin
        same_cls = (cls0 == cls1);
        st1_ok   = same_cls ? has_two[cls1] : has_one[cls1];
        any_br   = (cls0 == CLS_BR) || (cls1 == CLS_BR);
        issue0   = v0 && !flush && has_one[cls0] && (rob_free >= ROBC_W'(1));
        issue1   = issue0 && v1 && !any_br && st1_ok && (rob_free >= ROBC_W'(2));
    end
endmodule

// File: rtl/ipk_rename_table.sv
// Register status table: one pending flag and one producer ROB tag per register.
// Write priority: slot 1 over slot 0 over commit. Flush clears every pending flag.
// Reads are combinational and show the state before the coming edge.
module ipk_rename_table #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 4,
    parameter int NRD      = 4,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   wr0_en,
    input  logic [REG_W-1:0]       wr0_reg,
    input  logic [TAG_W-1:0]       wr0_tag,
    input  logic                   wr1_en,
    input  logic [REG_W-1:0]       wr1_reg,
    input  logic [TAG_W-1:0]       wr1_tag,
    input  logic                   cm_en,
    input  logic [REG_W-1:0]       cm_reg,
    input  logic [TAG_W-1:0]       cm_tag,
    input  logic [NRD*REG_W-1:0]   rd_reg,
    output logic [NRD-1:0]         rd_pend,
    output logic [NRD*TAG_W-1:0]   rd_tag
);
    logic [NUM_REGS-1:0] busy;
    logic [TAG_W-1:0]    tag_q [NUM_REGS];

    // State update: reset, flush, then issue writes and matching commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
            for (int r = 0; r < NUM_REGS; r++) tag_q[r] <= '0;
        end else if (flush) begin
            busy <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (wr1_en && wr1_reg == REG_W'(r)) begin
                    busy[r]  <= 1'b1;
                    tag_q[r] <= wr1_tag;
                end else if (wr0_en && wr0_reg == REG_W'(r)) begin
                    busy[r]  <= 1'b1;
                    tag_q[r] <= wr0_tag;
                end else if (cm_en && cm_reg == REG_W'(r) && busy[r] && tag_q[r] == cm_tag) begin
                    busy[r] <= 1'b0;
                end
            end
        end
    end

    // Read ports: a register that is not pending reports tag zero.
    for (genvar i = 0; i < NRD; i++) begin : g_rd
        logic [REG_W-1:0] idx;
        assign idx                    = rd_reg[i*REG_W +: REG_W];
        assign rd_pend[i]             = busy[idx];
        assign rd_tag[i*TAG_W +: TAG_W] = busy[idx] ? tag_q[idx] : '0;
    end

    // R10: when both slots write one register, slot 1's tag survives the edge.
    a_r10_last_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && wr0_en && wr1_en && wr0_reg == wr1_reg)
        |=> (busy[$past(wr1_reg)] && tag_q[$past(wr1_reg)] == $past(wr1_tag)));

    // R6: a flush leaves no register pending.
    a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ($countones(busy) == 0));

    // R11: a commit with a wrong tag and no competing write keeps the entry.
    a_r11_tag_mismatch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && cm_en && busy[cm_reg] && tag_q[cm_reg] != cm_tag)
        |=> busy[$past(cm_reg)]);
endmodule

// File: rtl/ipk_dep_resolve.sv
// Resolves the sources of slot 1 against slot 0's destination inside the packet.
// A match takes slot 0's ROB tag; otherwise the table lookup passes through.
module ipk_dep_resolve #(
    parameter int REG_W = 5,
    parameter int TAG_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               p_valid,
    input  logic               p_we,
    input  logic [REG_W-1:0]   p_dst,
    input  logic [TAG_W-1:0]   p_tag,
    input  logic [2*REG_W-1:0] c_src,
    input  logic [1:0]         tbl_pend,
    input  logic [2*TAG_W-1:0] tbl_tag,
    output logic [1:0]         o_pend,
    output logic [2*TAG_W-1:0] o_tag
);
    logic [1:0] hit;

    // One comparator and bypass multiplexer per source of slot 1.
    for (genvar s = 0; s < 2; s++) begin : g_src
        assign hit[s]               = p_valid && p_we && (c_src[s*REG_W +: REG_W] == p_dst);
        assign o_pend[s]            = hit[s] | tbl_pend[s];
        assign o_tag[s*TAG_W +: TAG_W] = hit[s] ? p_tag : tbl_tag[s*TAG_W +: TAG_W];
    end

    // R8: a source written by slot 0 waits on slot 0's tag.
    a_r8_bypass_src1: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_we && c_src[REG_W-1:0] == p_dst)
        |-> (o_pend[0] && o_tag[TAG_W-1:0] == p_tag));
    a_r8_bypass_src2: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_we && c_src[2*REG_W-1:REG_W] == p_dst)
        |-> (o_pend[1] && o_tag[2*TAG_W-1:TAG_W] == p_tag));
endmodule

// File: rtl/ipk_issue_checker.sv
// Top level of the two-wide issue packet checker.
// Joins the resource check, the register status table and the in-packet bypass.
// Assumes rob_free never exceeds ROB_DEPTH and rob_tail < ROB_DEPTH.
module ipk_issue_checker
    import ipk_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int ROB_DEPTH = 16,
    parameter int CNT_W     = 3,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int TAG_W    = $clog2(ROB_DEPTH),
    localparam int ROBC_W   = $clog2(ROB_DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       q0_valid,
    input  logic [1:0]                 q0_class,
    input  logic [REG_W-1:0]           q0_src1,
    input  logic [REG_W-1:0]           q0_src2,
    input  logic [REG_W-1:0]           q0_dst,
    input  logic                       q0_dst_we,
    input  logic                       q1_valid,
    input  logic [1:0]                 q1_class,
    input  logic [REG_W-1:0]           q1_src1,
    input  logic [REG_W-1:0]           q1_src2,
    input  logic [REG_W-1:0]           q1_dst,
    input  logic                       q1_dst_we,
    input  logic [NUM_CLASS*CNT_W-1:0] rs_free,
    input  logic [ROBC_W-1:0]          rob_free,
    input  logic [TAG_W-1:0]           rob_tail,
    input  logic                       commit_valid,
    input  logic [REG_W-1:0]           commit_reg,
    input  logic [TAG_W-1:0]           commit_tag,
    output logic                       issue0,
    output logic                       issue1,
    output logic [TAG_W-1:0]           dst_tag0,
    output logic [TAG_W-1:0]           dst_tag1,
    output logic                       s0a_pend,
    output logic [TAG_W-1:0]           s0a_tag,
    output logic                       s0b_pend,
    output logic [TAG_W-1:0]           s0b_tag,
    output logic                       s1a_pend,
    output logic [TAG_W-1:0]           s1a_tag,
    output logic                       s1b_pend,
    output logic [TAG_W-1:0]           s1b_tag
);
    // ROB tag allocation for the packet, wrapping at the buffer depth.
    assign dst_tag0 = rob_tail;
    assign dst_tag1 = (rob_tail == TAG_W'(ROB_DEPTH - 1)) ? '0 : rob_tail + TAG_W'(1);

    ipk_resource_check #(.CNT_W(CNT_W), .ROBC_W(ROBC_W)) u_res (
        .flush    (flush),
        .v0       (q0_valid),
        .v1       (q1_valid),
        .cls0     (unit_cls_e'(q0_class)),
        .cls1     (unit_cls_e'(q1_class)),
        .rs_free  (rs_free),
        .rob_free (rob_free),
        .issue0   (issue0),
        .issue1   (issue1)
    );

    logic [3:0]         rd_pend;
    logic [4*TAG_W-1:0] rd_tag;

    ipk_rename_table #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .NRD(4)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr0_en  (issue0 && q0_dst_we),
        .wr0_reg (q0_dst),
        .wr0_tag (dst_tag0),
        .wr1_en  (issue1 && q1_dst_we),
        .wr1_reg (q1_dst),
        .wr1_tag (dst_tag1),
        .cm_en   (commit_valid),
        .cm_reg  (commit_reg),
        .cm_tag  (commit_tag),
        .rd_reg  ({q1_src2, q1_src1, q0_src2, q0_src1}),
        .rd_pend (rd_pend),
        .rd_tag  (rd_tag)
    );

    // Slot 0 sources come straight from the table.
    assign s0a_pend = rd_pend[0];
    assign s0a_tag  = rd_tag[0*TAG_W +: TAG_W];
    assign s0b_pend = rd_pend[1];
    assign s0b_tag  = rd_tag[1*TAG_W +: TAG_W];

    logic [1:0]         s1_pend;
    logic [2*TAG_W-1:0] s1_tag;

    ipk_dep_resolve #(.REG_W(REG_W), .TAG_W(TAG_W)) u_dep (
        .clk      (clk),
        .rst_n    (rst_n),
        .p_valid  (q0_valid),
        .p_we     (q0_dst_we),
        .p_dst    (q0_dst),
        .p_tag    (dst_tag0),
        .c_src    ({q1_src2, q1_src1}),
        .tbl_pend (rd_pend[3:2]),
        .tbl_tag  (rd_tag[4*TAG_W-1:2*TAG_W]),
        .o_pend   (s1_pend),
        .o_tag    (s1_tag)
    );

    assign s1a_pend = s1_pend[0];
    assign s1a_tag  = s1_tag[TAG_W-1:0];
    assign s1b_pend = s1_pend[1];
    assign s1b_tag  = s1_tag[2*TAG_W-1:TAG_W];

    // R5: slot 1 only issues behind slot 0.
    a_r5_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 |-> issue0);
    // R2: two ROB entries are needed for a pair.
    a_r2_rob_pair: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 |-> (rob_free >= ROBC_W'(2)));
    // R4: a branch in the packet keeps slot 1 back.
    a_r4_branch_alone: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 |-> (q0_class != 2'd3 && q1_class != 2'd3));
    // R6: nothing issues during a flush.
    a_r6_no_issue_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!issue0 && !issue1));
endmodule

// File: tb/ipk_issue_checker_tb_top.sv
`timescale 1ns/1ps
module ipk_issue_checker_tb_top;
    localparam int NUM_REGS  = 32;
    localparam int ROB_DEPTH = 16;
    localparam int CNT_W     = 3;
    localparam int REG_W     = $clog2(NUM_REGS);
    localparam int TAG_W     = $clog2(ROB_DEPTH);
    localparam int ROBC_W    = $clog2(ROB_DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic q0_valid = 1'b0, q1_valid = 1'b0, q0_dst_we = 1'b0, q1_dst_we = 1'b0;
    logic [1:0] q0_class = '0, q1_class = '0;
    logic [REG_W-1:0] q0_src1 = '0, q0_src2 = '0, q0_dst = '0;
    logic [REG_W-1:0] q1_src1 = '0, q1_src2 = '0, q1_dst = '0;
    logic [4*CNT_W-1:0] rs_free = '0;
    logic [ROBC_W-1:0] rob_free = '0;
    logic [TAG_W-1:0] rob_tail = '0;
    logic commit_valid = 1'b0;
    logic [REG_W-1:0] commit_reg = '0;
    logic [TAG_W-1:0] commit_tag = '0;
    logic issue0, issue1, s0a_pend, s0b_pend, s1a_pend, s1b_pend;
    logic [TAG_W-1:0] dst_tag0, dst_tag1, s0a_tag, s0b_tag, s1a_tag, s1b_tag;

    always #2 clk = ~clk;

    ipk_issue_checker #(.NUM_REGS(NUM_REGS), .ROB_DEPTH(ROB_DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .q0_valid(q0_valid), .q0_class(q0_class), .q0_src1(q0_src1), .q0_src2(q0_src2),
        .q0_dst(q0_dst), .q0_dst_we(q0_dst_we),
        .q1_valid(q1_valid), .q1_class(q1_class), .q1_src1(q1_src1), .q1_src2(q1_src2),
        .q1_dst(q1_dst), .q1_dst_we(q1_dst_we),
        .rs_free(rs_free), .rob_free(rob_free), .rob_tail(rob_tail),
        .commit_valid(commit_valid), .commit_reg(commit_reg), .commit_tag(commit_tag),
        .issue0(issue0), .issue1(issue1), .dst_tag0(dst_tag0), .dst_tag1(dst_tag1),
        .s0a_pend(s0a_pend), .s0a_tag(s0a_tag), .s0b_pend(s0b_pend), .s0b_tag(s0b_tag),
        .s1a_pend(s1a_pend), .s1a_tag(s1a_tag), .s1b_pend(s1b_pend), .s1b_tag(s1b_tag)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit mb [NUM_REGS];
    int mt [NUM_REGS];
    bit e_i0, e_i1;
    int e_t0, e_t1;

    // One comparison with a FAIL line on mismatch.
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int free_of(input int c);
        return int'(rs_free[c*CNT_W +: CNT_W]);
    endfunction

    // Expected issue decisions and tags from the requirements.
    task automatic expect_issue();
        int need1;
        e_i0 = q0_valid && !flush && free_of(int'(q0_class)) >= 1 && rob_free >= 1;
        need1 = (q0_class == q1_class) ? 2 : 1;
        e_i1 = e_i0 && q1_valid && q0_class != 2'd3 && q1_class != 2'd3 &&
               rob_free >= 2 && free_of(int'(q1_class)) >= need1;
        e_t0 = int'(rob_tail);
        e_t1 = (int'(rob_tail) + 1) % ROB_DEPTH;
    endtask

    function automatic int tbl_tag(input int r);
        return mb[r] ? mt[r] : 0;
    endfunction

    // Compare every output against the model, before the coming edge.
    task automatic check_all();
        bit h1, h2;
        expect_issue();
        chk("R1", "issue0", int'(issue0), int'(e_i0));
        chk("R3", "issue1", int'(issue1), int'(e_i1));
        chk("R7", "dst_tag0", int'(dst_tag0), e_t0);
        chk("R7", "dst_tag1", int'(dst_tag1), e_t1);
        chk("R9", "s0a_pend", int'(s0a_pend), int'(mb[q0_src1]));
        chk("R9", "s0a_tag", int'(s0a_tag), tbl_tag(int'(q0_src1)));
        chk("R9", "s0b_pend", int'(s0b_pend), int'(mb[q0_src2]));
        chk("R9", "s0b_tag", int'(s0b_tag), tbl_tag(int'(q0_src2)));
        h1 = q0_valid && q0_dst_we && q1_src1 == q0_dst;
        h2 = q0_valid && q0_dst_we && q1_src2 == q0_dst;
        chk(h1 ? "R8" : "R9", "s1a_pend", int'(s1a_pend), h1 ? 1 : int'(mb[q1_src1]));
        chk(h1 ? "R8" : "R9", "s1a_tag", int'(s1a_tag), h1 ? e_t0 : tbl_tag(int'(q1_src1)));
        chk(h2 ? "R8" : "R9", "s1b_pend", int'(s1b_pend), h2 ? 1 : int'(mb[q1_src2]));
        chk(h2 ? "R8" : "R9", "s1b_tag", int'(s1b_tag), h2 ? e_t0 : tbl_tag(int'(q1_src2)));
    endtask

    // Model update at the edge, following R6, R10 and R11.
    task automatic model_edge();
        int w0, w1;
        if (flush) begin
            for (int r = 0; r < NUM_REGS; r++) mb[r] = 1'b0;
            return;
        end
        w0 = (e_i0 && q0_dst_we) ? int'(q0_dst) : -1;
        w1 = (e_i1 && q1_dst_we) ? int'(q1_dst) : -1;
        if (commit_valid && int'(commit_reg) != w0 && int'(commit_reg) != w1 &&
            mb[commit_reg] && mt[commit_reg] == int'(commit_tag))
            mb[commit_reg] = 1'b0;
        if (w0 >= 0) begin mb[w0] = 1'b1; mt[w0] = e_t0; end
        if (w1 >= 0) begin mb[w1] = 1'b1; mt[w1] = e_t1; end
    endtask

    // One cycle: check at negedge+1, update model at posedge, return at negedge.
    task automatic run_cycle();
        #1;
        check_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        q0_valid = 0; q1_valid = 0; q0_dst_we = 0; q1_dst_we = 0;
        flush = 0; commit_valid = 0; rob_free = 0;
    endtask

    // Read the table entry of a register through slot 0 without issuing.
    task automatic probe(input int r, input string req, input int exp_p, input int exp_t);
        idle_inputs();
        q0_src1 = REG_W'(r);
        #1;
        chk(req, "probe pend", int'(s0a_pend), exp_p);
        chk(req, "probe tag", int'(s0a_tag), exp_t);
        run_cycle();
    endtask

    function automatic logic [4*CNT_W-1:0] frees(input int a, input int m, input int f, input int b);
        return {CNT_W'(b), CNT_W'(f), CNT_W'(m), CNT_W'(a)};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired before the run ended");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < NUM_REGS; r++) begin mb[r] = 0; mt[r] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: the table comes out of reset with nothing pending.
        for (int r = 0; r < 8; r++) probe(r, "R12", 0, 0);

        // R1 and R3: an integer and a memory instruction both issue.
        idle_inputs();
        rs_free = frees(7, 7, 7, 7); rob_free = 16; rob_tail = 4'd3;
        q0_valid = 1; q0_class = 2'd0; q0_dst = 5'd1; q0_dst_we = 1;
        q1_valid = 1; q1_class = 2'd1; q1_dst = 5'd2; q1_dst_we = 1;
        q1_src1 = 5'd1; q1_src2 = 5'd9;
        #1; chk("R1", "dual issue0", int'(issue0), 1); chk("R3", "dual issue1", int'(issue1), 1);
        chk("R8", "bypass tag", int'(s1a_tag), 3);
        run_cycle();

        // R3: two integer instructions with a single free integer station.
        rs_free = frees(1, 7, 7, 7); q1_class = 2'd0; q0_dst_we = 0; q1_dst_we = 0;
        #1; chk("R3", "same class one station", int'(issue1), 0);
        run_cycle();
        rs_free = frees(2, 0, 0, 0);
        #1; chk("R3", "same class two stations", int'(issue1), 1);
        run_cycle();

        // R2: only one ROB entry free.
        rs_free = frees(7, 7, 7, 7); rob_free = 1; q1_class = 2'd2;
        #1; chk("R2", "one rob issue0", int'(issue0), 1); chk("R2", "one rob issue1", int'(issue1), 0);
        run_cycle();

        // R4: a branch in either slot keeps slot 1 back.
        rob_free = 16; q1_class = 2'd3;
        #1; chk("R4", "branch in slot 1", int'(issue1), 0); chk("R4", "slot 0 still", int'(issue0), 1);
        run_cycle();
        q0_class = 2'd3; q1_class = 2'd0;
        #1; chk("R4", "branch in slot 0", int'(issue1), 0);
        run_cycle();

        // R5: slot 0 has no station, slot 1 has all it needs.
        q0_class = 2'd2; q1_class = 2'd1; rs_free = frees(7, 7, 0, 7);
        #1; chk("R5", "blocked head issue0", int'(issue0), 0); chk("R5", "blocked head issue1", int'(issue1), 0);
        run_cycle();

        // R10: both slots write register 5; slot 1's tag stays.
        rs_free = frees(7, 7, 7, 7); rob_tail = 4'd15;
        q0_class = 2'd0; q1_class = 2'd1; q0_dst = 5'd5; q1_dst = 5'd5;
        q0_dst_we = 1; q1_dst_we = 1; q1_src1 = 5'd0; q1_src2 = 5'd0;
        #1; chk("R7", "tag wrap", int'(dst_tag1), 0);
        run_cycle();
        probe(5, "R10", 1, 0);

        // R11: a wrong commit tag keeps the entry; the right one clears it.
        idle_inputs(); commit_valid = 1; commit_reg = 5'd5; commit_tag = 4'd15;
        run_cycle();
        probe(5, "R11", 1, 0);
        idle_inputs(); commit_valid = 1; commit_reg = 5'd5; commit_tag = 4'd0;
        run_cycle();
        probe(5, "R11", 0, 0);

        // R6: a flush blocks issue and clears pending marks.
        idle_inputs(); rob_free = 16; rob_tail = 4'd6;
        q0_valid = 1; q0_class = 2'd0; q0_dst = 5'd7; q0_dst_we = 1;
        run_cycle();
        flush = 1; q0_dst = 5'd8;
        #1; chk("R6", "flush issue0", int'(issue0), 0);
        run_cycle();
        probe(7, "R6", 0, 0);
        probe(8, "R6", 0, 0);

        // Random mix checked against the model.
        for (int i = 0; i < 4000; i++) begin
            q0_valid = ($urandom % 8) != 0; q1_valid = ($urandom % 8) != 0;
            q0_class = 2'($urandom); q1_class = 2'($urandom);
            q0_src1 = REG_W'($urandom % 8); q0_src2 = REG_W'($urandom % 8);
            q1_src1 = REG_W'($urandom % 8); q1_src2 = REG_W'($urandom % 8);
            q0_dst = REG_W'($urandom % 8); q1_dst = REG_W'($urandom % 8);
            q0_dst_we = ($urandom % 4) != 0; q1_dst_we = ($urandom % 4) != 0;
            rs_free = frees($urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4);
            rob_free = ROBC_W'($urandom % 4);
            rob_tail = TAG_W'($urandom);
            flush = ($urandom % 16) == 0;
            commit_valid = ($urandom % 2) != 0;
            commit_reg = REG_W'($urandom % 8);
            commit_tag = (($urandom % 2) != 0) ? TAG_W'(mt[commit_reg]) : TAG_W'($urandom);
            run_cycle();
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule